// File: doc/BRIEF.md
# Register-mapped SPI command sequencer

This block is a host-side SPI master controlled through an eight-byte register window. The host places an opcode, the low two address bytes and up to four data bytes into the window. It then writes a mode byte. The upper nibble of that byte picks one of eleven fixed frame shapes, and the lower nibble supplies address bits 19:16. The block drives chip select, shifts the frame out in SPI mode 0 and stores any bytes it reads back into the data part of the window, where the host can fetch them.

A frame is built from up to five phases, always in this order: opcode, address, write data, dummy, read data. Each phase is one byte or more. The mode nibble alone decides which phases are present and how many bytes each one has. The serial clock is derived from the system clock through a divider value that the host supplies. A busy output covers the whole frame, from the mode write until chip select is released.

Top module: `spi_cmd_seq`

## Requirements
- R1: The window holds eight bytes: offset 0 is the opcode, offset 1 the mode byte, offsets 2 and 3 address bits 15:8 and 7:0, and offsets 4 to 7 the data bytes. When the block is idle, a host write to any offset is read back unchanged at that offset.
- R2: With no address phase, mode 1 sends only the opcode. Mode 2 sends the opcode and then the byte at offset 4. Mode 3 sends the opcode and then reads two bytes into offsets 4 and 5.
- R3: Modes 4, 5 and 6 send the opcode and then three address bytes: {4'b0000, mode[3:0]}, offset 2, offset 3. Mode 5 then sends offset 4. Mode 6 then sends offsets 4, 5, 6 and 7 in that order.
- R4: Mode 7 sends the opcode and the three address bytes, then one dummy byte of 0x00 inserted by the block, then reads four bytes into offsets 4 to 7.
- R5: Modes 8, 9, 10 and 11 send the opcode and the three address bytes, then read 1, 2, 3 and 4 bytes (mode minus 7) into offsets starting at 4. Data offsets beyond the read count keep their previous values.
- R6: A host write to offset 1 while idle starts a frame only when the mode nibble (bits 7:4) is 1 to 11. A nibble of 0 or 12 to 15 leaves busy low and chip select high.
- R7: Busy is high, and chip select is low, from the cycle after a starting mode write until the frame is released. The serial clock is low whenever chip select is high, so chip select falls before the first clock edge.
- R8: Bits are sent MSB first in SPI mode 0. MOSI changes only when the serial clock falls, and MISO is sampled on its rising edge. MOSI is 0 during dummy and read bytes.
- R9: Host writes to any offset while busy are ignored and do not start another frame.
- R10: Each serial clock level lasts clk_div+1 system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_div | input | DIV_W | Serial clock half period minus one, in system clocks |
| addr | input | 3 | Window offset for reads and writes |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Host write data |
| rd_data | output | 8 | Window byte at addr |
| busy | output | 1 | Frame in progress |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the target |
| spi_miso | input | 1 | Serial data from the target |

## Verification
The assertions assume that the host keeps clk_div constant while a frame runs and that spi_miso settles between a falling and the next rising serial clock edge. The bench changes the divider only between frames, when busy is low. Its target model updates MISO only on chip select falling or on serial clock falling, so every sample the block takes sees a settled value.

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] clk_div,
  input  logic [2:0]       addr,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  output logic [7:0]       rd_data,
  output logic             busy,
  output logic             spi_cs_n,
  output logic             spi_sck,
  output logic             spi_mosi,
  input  logic             spi_miso
);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_TAIL} phase_t;

  logic [7:0]       regs [8];
  phase_t           phase;
  logic [3:0]       k;
  logic [2:0]       bitn;
  logic [7:0]       tx, rx;
  logic             sck;
  logic [DIV_W-1:0] cnt;

  wire [3:0] m     = regs[1][7:4];
  wire       has_a = m >= 4'd4;
  logic [3:0] nw, nd, nr, last;

  always_comb begin
    nw   = (m == 4'd2 || m == 4'd5) ? 4'd1 : (m == 4'd6) ? 4'd4 : 4'd0;
    nd   = {3'b0, m == 4'd7};
    nr   = (m == 4'd3) ? 4'd2 : (m == 4'd7) ? 4'd4 : (m >= 4'd8) ? m - 4'd7 : 4'd0;
    last = nw + nd + nr + (has_a ? 4'd3 : 4'd0);
  end

  // {kind[1:0], read, slot[1:0]}; kind 0 opcode, 1 address, 2 write data, 3 zero byte
  function automatic logic [4:0] classify(input logic [3:0] idx, input logic ha,
                                          input logic [3:0] w, input logic [3:0] d);
    logic [3:0] j, r;
    j = idx - 4'd1 - (ha ? 4'd3 : 4'd0);
    r = j - w - d;
    if (idx == 4'd0)                 classify = 5'b00_0_00;
    else if (ha && idx <= 4'd3)      classify = {2'd1, 1'b0, 2'(idx - 4'd1)};
    else if (j < w)                  classify = {2'd2, 1'b0, j[1:0]};
    else if (j < w + d)              classify = 5'b11_0_00;
    else                             classify = {2'd3, 1'b1, r[1:0]};
  endfunction

  wire [4:0] cur = classify(k, has_a, nw, nd);
  wire [4:0] nxt = classify(k + 4'd1, has_a, nw, nd);

  logic [7:0] tx_next;
  always_comb begin
    case (nxt[4:3])
      2'd0: tx_next = regs[0];
      2'd1: tx_next = (nxt[1:0] == 2'd0) ? {4'h0, regs[1][3:0]} :
                      (nxt[1:0] == 2'd1) ? regs[2] : regs[3];
      2'd2: tx_next = regs[{1'b1, nxt[1:0]}];
      default: tx_next = 8'h00;
    endcase
  end

  wire tick    = cnt == '0;
  wire host_wr = wr_en && phase == S_IDLE;
  wire start   = host_wr && addr == 3'd1 && wr_data[7:4] != 4'd0 && wr_data[7:4] <= 4'd11;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) regs[i] <= '0;
      phase <= S_IDLE;
      k     <= '0;
      bitn  <= '0;
      tx    <= '0;
      rx    <= '0;
      sck   <= 1'b0;
      cnt   <= '0;
    end else begin
      if (host_wr) regs[addr] <= wr_data;
      case (phase)
        S_IDLE: if (start) begin
          phase <= S_RUN;
          k     <= '0;
          bitn  <= '0;
          tx    <= regs[0];
          cnt   <= clk_div;
          sck   <= 1'b0;
        end
        S_RUN: if (!tick) cnt <= cnt - 1'b1;
        else begin
          cnt <= clk_div;
          if (!sck) begin
            sck <= 1'b1;
            rx  <= {rx[6:0], spi_miso};
          end else begin
            sck <= 1'b0;
            if (bitn == 3'd7) begin
              if (cur[2]) regs[{1'b1, cur[1:0]}] <= rx;
              bitn <= '0;
              if (k == last) begin
                phase <= S_TAIL;
                tx    <= '0;
              end else begin
                k  <= k + 4'd1;
                tx <= tx_next;
              end
            end else begin
              bitn <= bitn + 3'd1;
              tx   <= {tx[6:0], 1'b0};
            end
          end
        end
        S_TAIL: if (tick) phase <= S_IDLE;
                else      cnt   <= cnt - 1'b1;
        default: phase <= S_IDLE;
      endcase
    end
  end

  assign rd_data  = regs[addr];
  assign busy     = phase != S_IDLE;
  assign spi_cs_n = phase == S_IDLE;
  assign spi_sck  = sck;
  assign spi_mosi = tx[7];

  a_r6_bad_mode_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd1 && !busy && (wr_data[7:4] == 4'd0 || wr_data[7:4] >= 4'd12))
      |=> (!busy && spi_cs_n));

  a_r6_good_mode_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd1 && !busy && wr_data[7:4] != 4'd0 && wr_data[7:4] < 4'd12)
      |=> (busy && !spi_cs_n));

  a_r7_sck_low_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);

  a_r8_mosi_holds_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sck && !spi_cs_n) |-> $stable(spi_mosi));

  a_r8_mosi_zero_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == S_RUN && cur[4:3] == 2'd3) |-> !spi_mosi);

  a_r9_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en && addr == 3'd0) |=> $stable(regs[0]));

endmodule

// File: tb/test_spi_cmd_seq.sv
module test_spi_cmd_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] clk_div = 8'd0;
  logic [2:0] addr = 3'd0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] rd_data;
  logic       busy, spi_cs_n, spi_sck, spi_mosi;
  logic       spi_miso = 1'b0;

  spi_cmd_seq #(.DIV_W(8)) i_spi_cmd_seq (
    .clk(clk), .rst_n(rst_n), .clk_div(clk_div), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .busy(busy), .spi_cs_n(spi_cs_n),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso));

  always #2 clk = ~clk;

  int nchk = 0, nfail = 0, frames = 0;
  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic [7:0] seed = 8'h11;

  function automatic logic [7:0] resp(input int pos, input logic [7:0] s);
    return (8'h5A ^ 8'(pos * 8'h3B)) + s;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // target model and monitor
  int bitc = 0, bpos = 0;
  logic [7:0] sh = 8'd0;
  time t_rise = 0;
  always @(negedge spi_cs_n) begin
    frames++;
    bitc = 0; bpos = 0;
    chk(spi_sck == 1'b0, "R7 sck low at select", 32'(spi_sck), 0);
    spi_miso = resp(0, seed)[7];
  end
  always @(posedge spi_sck) if (!spi_cs_n) begin
    t_rise = $time;
    sh = {sh[6:0], spi_mosi};
    bitc++;
    if (bitc == 8) begin
      if (exp_q.size() == 0) chk(0, "R2 extra byte", 32'(sh), 0);
      else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(sh == e, t, 32'(sh), 32'(e));
      end
      bitc = 0;
      bpos++;
    end
  end
  always @(negedge spi_sck) if (!spi_cs_n) begin
    if (bpos == 0 && bitc == 1)
      chk(($time - t_rise) == (clk_div + 1) * 4, "R10 sck high width",
          32'($time - t_rise), 32'((clk_div + 1) * 4));
    spi_miso = resp(bpos, seed)[7 - bitc];
  end

  task automatic host_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic host_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rd_data;
  endtask

  task automatic push(input logic [7:0] b, input string t);
    exp_q.push_back(b); tag_q.push_back(t);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // driver: loads operands, predicts the frame, starts it and checks the window afterwards
  task automatic run(input logic [7:0] mode, input logic [7:0] op, input logic [7:0] a2,
                     input logic [7:0] a3, input logic [31:0] wd, input string tag);
    int m, nw, nd, nr, pos;
    logic [7:0] d;
    m  = int'(mode[7:4]);
    nw = (m == 2 || m == 5) ? 1 : (m == 6) ? 4 : 0;
    nd = (m == 7) ? 1 : 0;
    nr = (m == 3) ? 2 : (m == 7) ? 4 : (m >= 8) ? m - 7 : 0;
    host_wr(3'd0, op); host_wr(3'd2, a2); host_wr(3'd3, a3);
    for (int i = 0; i < 4; i++) host_wr(3'(4 + i), wd[31 - 8*i -: 8]);
    seed = seed + 8'h29;
    push(op, {tag, " opcode"});
    if (m >= 4) begin
      push({4'h0, mode[3:0]}, "R3 address high");
      push(a2, "R3 address mid");
      push(a3, "R3 address low");
    end
    for (int i = 0; i < nw; i++) push(wd[31 - 8*i -: 8], {tag, " write data"});
    if (nd != 0) push(8'h00, "R4 dummy byte");
    for (int i = 0; i < nr; i++) push(8'h00, "R8 mosi zero on read");
    pos = 1 + ((m >= 4) ? 3 : 0) + nw + nd;
    host_wr(3'd1, mode);
    chk(busy && !spi_cs_n, "R7 busy after start", 32'({busy, spi_cs_n}), 32'b10);
    wait_idle();
    chk(exp_q.size() == 0, {tag, " frame length"}, 32'(exp_q.size()), 0);
    exp_q.delete(); tag_q.delete();
    chk(spi_cs_n && !busy, "R7 released", 32'({busy, spi_cs_n}), 32'b01);
    for (int i = 0; i < 4; i++) begin
      host_rd(3'(4 + i), d);
      if (i < nr) chk(d == resp(pos + i, seed), {tag, " read capture"}, 32'(d), 32'(resp(pos + i, seed)));
      else        chk(d == wd[31 - 8*i -: 8], "R5 unread data kept", 32'(d), 32'(wd[31 - 8*i -: 8]));
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    int f0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && spi_cs_n && !spi_sck, "R7 reset state", 32'({busy, spi_cs_n, spi_sck}), 32'b010);

    // R1 window readback, mode nibble 0 keeps it idle (R6)
    for (int i = 0; i < 8; i++) host_wr(3'(i), 8'(8'h0A + 8'(i * 8'h21)) & ((i == 1) ? 8'h0F : 8'hFF));
    for (int i = 0; i < 8; i++) begin
      logic [7:0] e;
      e = 8'(8'h0A + 8'(i * 8'h21)) & ((i == 1) ? 8'h0F : 8'hFF);
      host_rd(3'(i), d);
      chk(d == e, "R1 window readback", 32'(d), 32'(e));
    end
    f0 = frames;
    host_wr(3'd1, 8'hC3); repeat (4) @(negedge clk);
    chk(!busy && spi_cs_n, "R6 mode C ignored", 32'({busy, spi_cs_n}), 32'b01);
    host_wr(3'd1, 8'hF0); repeat (4) @(negedge clk);
    chk(!busy && spi_cs_n, "R6 mode F ignored", 32'({busy, spi_cs_n}), 32'b01);
    host_wr(3'd1, 8'h07); repeat (4) @(negedge clk);
    chk(frames == f0, "R6 no frame started", 32'(frames), 32'(f0));

    clk_div = 8'd0;
    run(8'h10, 8'h06, 8'h00, 8'h00, 32'hA1B2C3D4, "R2 mode1");
    run(8'h25, 8'h01, 8'h00, 8'h00, 32'h96B2C3D4, "R2 mode2");
    run(8'h30, 8'h9F, 8'h00, 8'h00, 32'h11223344, "R2 mode3");
    clk_div = 8'd1;
    run(8'h4A, 8'h20, 8'h12, 8'h34, 32'h55667788, "R3 mode4");
    run(8'h5F, 8'h02, 8'hFE, 8'h01, 32'hC3000000, "R3 mode5");
    run(8'h63, 8'h02, 8'h80, 8'h7F, 32'h0123ABCD, "R3 mode6");
    clk_div = 8'd3;
    run(8'h75, 8'h0B, 8'h44, 8'h55, 32'hDEADBEEF, "R4 mode7");
    clk_div = 8'd2;
    run(8'h82, 8'h03, 8'h10, 8'h20, 32'hF0E1D2C3, "R5 mode8");
    run(8'h93, 8'h03, 8'h30, 8'h40, 32'hB4A59687, "R5 mode9");
    run(8'hA4, 8'h03, 8'h50, 8'h60, 32'h78695A4B, "R5 modeA");
    run(8'hB7, 8'h03, 8'h70, 8'h80, 32'h3C2D1E0F, "R5 modeB");

    // R9 writes during a frame are ignored
    clk_div = 8'd7;
    host_wr(3'd0, 8'hAB); host_wr(3'd4, 8'h5C); host_wr(3'd2, 8'h66);
    push(8'hAB, "R9 opcode");
    f0 = frames;
    host_wr(3'd1, 8'h10);
    host_wr(3'd0, 8'hEE); host_wr(3'd4, 8'h77); host_wr(3'd2, 8'h99); host_wr(3'd1, 8'hB0);
    wait_idle();
    chk(exp_q.size() == 0, "R9 frame length", 32'(exp_q.size()), 0);
    exp_q.delete(); tag_q.delete();
    chk(frames == f0 + 1, "R9 single frame", 32'(frames), 32'(f0 + 1));
    host_rd(3'd0, d); chk(d == 8'hAB, "R9 opcode kept", 32'(d), 32'hAB);
    host_rd(3'd4, d); chk(d == 8'h5C, "R9 data kept", 32'(d), 32'h5C);
    host_rd(3'd2, d); chk(d == 8'h66, "R9 address kept", 32'(d), 32'h66);
    host_rd(3'd1, d); chk(d == 8'h10, "R9 mode kept", 32'(d), 32'h10);

    finish_run();
  end
endmodule